// File: doc/BRIEF.md
# Serial Flash Sequential Byte Programmer

This controller writes a run of consecutive bytes into a serial flash that supports an address-auto-increment program mode. A user gives a 24-bit start address and a byte count with a one-cycle `start` pulse. The data bytes then arrive on a ready/valid stream. The controller masters the serial bus in mode 0. It opens the run with a write-enable frame. The first program frame carries the opcode, three address bytes and the first data byte. Each later program frame carries only the opcode and one data byte, and the flash advances the address by itself.

Between program frames the flash is busy writing the previous byte. A parameter selects how the controller waits for it. It can read the status register until the busy bit clears, or it can wait a fixed number of clock cycles. After the last byte the controller sends write-disable, then reads status until the flash is idle, and then pulses `done`. In polling mode it also watches the write-enable latch. If the flash drops the latch early, for example at a protected boundary or at the top of the array, the controller abandons the run and pulses `error`.

Top module: `aai_prog_seq`

## Requirements
- R1: While reset is held, `cs_n` is 1 and `sck`, `in_ready`, `done` and `error` are all 0.
- R2: Bus mode 0. `sck` idles low and is low whenever `cs_n` is high. `mosi` changes only while `sck` is low, with the most significant bit first. `miso` is sampled on the rising `sck` edge, so status bit values are read correctly.
- R3: A run with a nonzero count begins with a frame that holds only the write-enable opcode 06h.
- R4: The first program frame is AFh, address bits [23:16], [15:8], [7:0], then data byte 1. Every later program frame is AFh followed by one data byte, with no address.
- R5: Between any two frames, `cs_n` stays high for at least CS_HIGH_CYC clock cycles.
- R6: In polling mode (POLL_BUSY=1), each program frame is followed by status frames (05h, then one read byte) until status bit 0 (busy) reads 0. No program frame is issued while the flash is busy.
- R7: In fixed-wait mode (POLL_BUSY=0), the controller waits TBP_CYC cycles after each program frame and issues no status read between bytes.
- R8: `in_ready` is 1 only while the controller waits for the next byte, which is after the wait for the previous byte has finished and while `cs_n` is high. A byte is taken on a cycle with `in_ready` and `in_valid` both 1.
- R9: After the last byte, the controller sends 04h alone in a frame, then reads status until busy is 0, then pulses `done` for exactly one cycle.
- R10: In polling mode, if status bit 1 (write-enable latch) reads 0 after busy clears while bytes remain, the controller pulses `error` and issues no further frame, including no 04h.
- R11: A start with `byte_count` 0 pulses `done` without any bus frame.
- R12: `done` and `error` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run (taken only when idle) |
| start_addr | input | 24 | Flash address of the first byte |
| byte_count | input | CNT_W | Number of bytes in the run |
| in_data | input | 8 | Next data byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Controller takes a byte this cycle if valid |
| done | output | 1 | One-cycle pulse: run finished normally |
| error | output | 1 | One-cycle pulse: write-enable latch lost mid-run |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Embedded properties check the bus timing rules on every cycle. They cover the `mosi` hold while `sck` is high, `sck` staying low outside a frame, the minimum chip-select high time, the handshake happening only between frames, and the one-cycle and exclusive end pulses. The frame contents can only be shown by the bench scenarios, which run against a behavioural flash model. These scenarios cover the opcode and address order, the data landing at the right addresses, the number of status polls, the loss of the write-enable latch at a boundary and the zero-length run.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;

    localparam int          ADDR_W   = 24;
    localparam logic [7:0]  OP_WREN  = 8'h06;
    localparam logic [7:0]  OP_WRDI  = 8'h04;
    localparam logic [7:0]  OP_RDSR  = 8'h05;
    localparam logic [7:0]  OP_AAI   = 8'hAF;
    localparam int          BUSY_BIT = 0;
    localparam int          WEL_BIT  = 1;

    typedef enum logic [2:0] {
        FR_WREN,
        FR_PROG_FIRST,
        FR_PROG_NEXT,
        FR_STATUS,
        FR_WRDI
    } frame_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_GAP,
        ST_PAUSE,
        ST_WAIT_DATA
    } state_e;

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       fin,
    output logic [7:0] rx
);
    localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    typedef struct packed {
        logic          active;
        logic          sck;
        logic          fin;
        logic [DW-1:0] div;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic [7:0]    rx;
    } shf_t;

    shf_t sh_q, sh_d;

    always_comb begin
        sh_d     = sh_q;
        sh_d.fin = 1'b0;
        if (!sh_q.active) begin
            if (go) begin
                sh_d.active = 1'b1;
                sh_d.sck    = 1'b0;
                sh_d.div    = '0;
                sh_d.bitn   = '0;
                sh_d.sh     = tx;
            end
        end else if (sh_q.div == DW'(HALF_CYC - 1)) begin
            sh_d.div = '0;
            if (!sh_q.sck) begin
                sh_d.sck = 1'b1;
                sh_d.rx  = {sh_q.rx[6:0], miso};
            end else begin
                sh_d.sck = 1'b0;
                if (sh_q.bitn == 3'd7) begin
                    sh_d.active = 1'b0;
                    sh_d.fin    = 1'b1;
                end else begin
                    sh_d.bitn = sh_q.bitn + 3'd1;
                    sh_d.sh   = {sh_q.sh[6:0], 1'b0};
                end
            end
        end else begin
            sh_d.div = sh_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck  = sh_q.sck;
    assign mosi = sh_q.sh[7];
    assign fin  = sh_q.fin;
    assign rx   = sh_q.rx;

    // R2: data is held for the whole high phase of the clock
    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R2: a byte completes with the clock back at idle low
    assert_fin_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !sck);

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // the counter never leaves zero without a load
    assert_timer_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq
    import aai_seq_pkg::*;
#(
    parameter int CLK_HALF    = 2,
    parameter int CS_HIGH_CYC = 4,
    parameter int POLL_BUSY   = 1,
    parameter int TBP_CYC     = 600,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              done,
    output logic              error,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int TMR_MAX = (TBP_CYC > CS_HIGH_CYC) ? TBP_CYC : CS_HIGH_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int GW      = $clog2(CS_HIGH_CYC + 1) + 1;

    typedef struct packed {
        state_e             st;
        frame_e             fr;
        logic [2:0]         idx;
        logic               cs_n;
        logic               go;
        logic [7:0]         tx;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   left;
        logic [7:0]         data;
        logic [1:0]         stat;
        logic               first;
        logic               closing;
        logic               done;
        logic               err;
        logic               tload;
        logic [TMR_W-1:0]   tval;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic       shf_fin;
    logic [7:0] shf_rx;
    logic       tmr_zero;
    logic       unused_stat_hi;

    function automatic logic [2:0] last_idx(frame_e f);
        case (f)
            FR_PROG_FIRST: last_idx = 3'd4;
            FR_PROG_NEXT:  last_idx = 3'd1;
            FR_STATUS:     last_idx = 3'd1;
            default:       last_idx = 3'd0;
        endcase
    endfunction

    function automatic logic [7:0] byte_of(frame_e f, logic [2:0] i,
                                           logic [ADDR_W-1:0] a, logic [7:0] dat);
        case (f)
            FR_WREN:   byte_of = OP_WREN;
            FR_WRDI:   byte_of = OP_WRDI;
            FR_STATUS: byte_of = (i == 3'd0) ? OP_RDSR : 8'h00;
            FR_PROG_FIRST: begin
                case (i)
                    3'd0:    byte_of = OP_AAI;
                    3'd1:    byte_of = a[23:16];
                    3'd2:    byte_of = a[15:8];
                    3'd3:    byte_of = a[7:0];
                    default: byte_of = dat;
                endcase
            end
            default:   byte_of = (i == 3'd0) ? OP_AAI : dat;
        endcase
    endfunction

    always_comb begin
        logic   launch;
        frame_e nfr;
        launch = 1'b0;
        nfr    = FR_WREN;

        ctl_d       = ctl_q;
        ctl_d.go    = 1'b0;
        ctl_d.done  = 1'b0;
        ctl_d.err   = 1'b0;
        ctl_d.tload = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.addr    = start_addr;
                    ctl_d.left    = byte_count;
                    ctl_d.first   = 1'b1;
                    ctl_d.closing = 1'b0;
                    if (byte_count == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        launch = 1'b1;
                        nfr    = FR_WREN;
                    end
                end
            end

            ST_FRAME: begin
                if (shf_fin) begin
                    if (ctl_q.idx == last_idx(ctl_q.fr)) begin
                        ctl_d.cs_n  = 1'b1;
                        ctl_d.st    = ST_GAP;
                        ctl_d.tload = 1'b1;
                        ctl_d.tval  = TMR_W'(CS_HIGH_CYC);
                        if (ctl_q.fr == FR_STATUS)
                            ctl_d.stat = shf_rx[1:0];
                        if (ctl_q.fr == FR_PROG_FIRST || ctl_q.fr == FR_PROG_NEXT)
                            ctl_d.left = ctl_q.left - 1'b1;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 3'd1;
                        ctl_d.go  = 1'b1;
                        ctl_d.tx  = byte_of(ctl_q.fr, ctl_q.idx + 3'd1, ctl_q.addr, ctl_q.data);
                    end
                end
            end

            ST_GAP: begin
                if (tmr_zero && !ctl_q.tload) begin
                    case (ctl_q.fr)
                        FR_WREN: ctl_d.st = ST_WAIT_DATA;
                        FR_PROG_FIRST, FR_PROG_NEXT: begin
                            if (POLL_BUSY != 0) begin
                                launch = 1'b1;
                                nfr    = FR_STATUS;
                            end else begin
                                ctl_d.st    = ST_PAUSE;
                                ctl_d.tload = 1'b1;
                                ctl_d.tval  = TMR_W'(TBP_CYC);
                            end
                        end
                        FR_STATUS: begin
                            if (ctl_q.stat[BUSY_BIT]) begin
                                launch = 1'b1;
                                nfr    = FR_STATUS;
                            end else if (ctl_q.closing) begin
                                ctl_d.done = 1'b1;
                                ctl_d.st   = ST_IDLE;
                            end else if (ctl_q.left == '0) begin
                                launch = 1'b1;
                                nfr    = FR_WRDI;
                            end else if (!ctl_q.stat[WEL_BIT]) begin
                                ctl_d.err = 1'b1;
                                ctl_d.st  = ST_IDLE;
                            end else begin
                                ctl_d.st = ST_WAIT_DATA;
                            end
                        end
                        default: begin
                            ctl_d.closing = 1'b1;
                            launch        = 1'b1;
                            nfr           = FR_STATUS;
                        end
                    endcase
                end
            end

            ST_PAUSE: begin
                if (tmr_zero && !ctl_q.tload) begin
                    if (ctl_q.left == '0) begin
                        launch = 1'b1;
                        nfr    = FR_WRDI;
                    end else begin
                        ctl_d.st = ST_WAIT_DATA;
                    end
                end
            end

            default: begin
                if (in_valid) begin
                    ctl_d.data  = in_data;
                    ctl_d.first = 1'b0;
                    launch      = 1'b1;
                    nfr         = ctl_q.first ? FR_PROG_FIRST : FR_PROG_NEXT;
                end
            end
        endcase

        if (launch) begin
            ctl_d.st   = ST_FRAME;
            ctl_d.fr   = nfr;
            ctl_d.idx  = '0;
            ctl_d.cs_n = 1'b0;
            ctl_d.go   = 1'b1;
            ctl_d.tx   = byte_of(nfr, 3'd0, ctl_d.addr, ctl_d.data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.cs_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    spi_byte_shifter #(.HALF_CYC(CLK_HALF)) u_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (ctl_q.go),
        .tx    (ctl_q.tx),
        .miso  (miso),
        .sck   (sck),
        .mosi  (mosi),
        .fin   (shf_fin),
        .rx    (shf_rx)
    );

    wait_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctl_q.tload),
        .val   (ctl_q.tval),
        .zero  (tmr_zero)
    );

    assign unused_stat_hi = ^shf_rx[7:2];
    assign in_ready = (ctl_q.st == ST_WAIT_DATA);
    assign cs_n     = ctl_q.cs_n;
    assign done     = ctl_q.done;
    assign error    = ctl_q.err;

    // cycles chip select has been high, saturating; used by the R5 check
    logic [GW-1:0] hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            hi_cnt <= GW'(CS_HIGH_CYC);
        else if (!cs_n)                        hi_cnt <= '0;
        else if (hi_cnt < GW'(CS_HIGH_CYC))    hi_cnt <= hi_cnt + 1'b1;
    end

    assert_cs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= GW'(CS_HIGH_CYC)));

    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_ready_between_frames_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> cs_n);

    assert_single_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_error_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (!error && cs_n));

endmodule

// File: tb/aai_prog_seq_test.sv
module aai_flash_model (
    input  logic              clk,
    input  logic              clear,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    input  logic [15:0]       busy_cyc,
    input  logic [23:0]       end_addr,
    output int                n_wren,
    output int                n_wrdi,
    output int                n_rdsr,
    output int                n_prog,
    output int                viol,
    output int                min_gap,
    output logic [23:0]       first_addr,
    output logic [63:0][7:0]  mem
);
    logic [7:0]  fb [0:7];
    logic [7:0]  cur, snap;
    logic [23:0] addr;
    logic        wel, aai, sck_p, in_fr;
    int          nbits, busy, gap;

    initial miso = 1'b0;

    task automatic store_byte(input logic [7:0] val);
        mem[addr[5:0]] = val;
        n_prog++;
        busy = busy_cyc;
        if (addr == end_addr) begin
            wel = 1'b0;
            aai = 1'b0;
        end
    endtask

    task automatic end_frame();
        int nb;
        nb = nbits / 8;
        gap = 0;
        if ((nbits % 8) != 0 || nb == 0) viol++;
        else if (fb[0] == 8'h06 && nb == 1) begin wel = 1'b1; n_wren++; end
        else if (fb[0] == 8'h04 && nb == 1) begin wel = 1'b0; aai = 1'b0; n_wrdi++; end
        else if (fb[0] == 8'h05) n_rdsr++;
        else if (fb[0] == 8'hAF && nb == 5) begin
            if (busy > 0 || !wel || aai) viol++;
            else begin
                addr = {fb[1], fb[2], fb[3]};
                first_addr = addr;
                aai = 1'b1;
                store_byte(fb[4]);
            end
        end else if (fb[0] == 8'hAF && nb == 2) begin
            if (busy > 0 || !aai) viol++;
            else begin
                addr = addr + 24'd1;
                store_byte(fb[1]);
            end
        end else viol++;
    endtask

    always @(negedge clk) begin
        if (clear) begin
            n_wren = 0; n_wrdi = 0; n_rdsr = 0; n_prog = 0; viol = 0;
            min_gap = 100000; gap = 100000; busy = 0; nbits = 0;
            wel = 1'b0; aai = 1'b0; in_fr = 1'b0; first_addr = '0;
            addr = '0; cur = '0; snap = '0;
            for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
        end else begin
            if (cs_n) begin
                if (in_fr) end_frame();
                in_fr = 1'b0;
                nbits = 0;
                if (gap < 100000) gap++;
            end else begin
                if (!in_fr) begin
                    if (gap < min_gap) min_gap = gap;
                    in_fr = 1'b1;
                end
                if (sck && !sck_p) begin
                    cur = {cur[6:0], mosi};
                    nbits++;
                    if ((nbits % 8) == 0 && nbits <= 64) fb[nbits/8 - 1] = cur;
                    if (nbits == 8 && cur == 8'h05) snap = {6'b0, wel, (busy > 0)};
                end
                if (!sck && sck_p && nbits >= 8 && nbits < 16) miso = snap[15 - nbits];
            end
            if (busy > 0) busy--;
        end
        sck_p = sck;
    end
endmodule

module aai_prog_seq_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CS_HI = 3;
    localparam int TBP   = 40;

    typedef struct packed {
        logic [23:0] addr;
        logic [15:0] cnt;
        logic [15:0] busy;
        logic [23:0] end_a;
        logic        err;
        logic [15:0] prog;
        logic [7:0]  rdsr;
    } vec_t;

    // rdsr 8'hFF means the poll count depends on timing and is not checked
    localparam vec_t VECS [6] = '{
        '{24'h000010, 16'd1, 16'd20, 24'hFFFFFF, 1'b0, 16'd1, 8'hFF},
        '{24'h123405, 16'd4, 16'd0,  24'hFFFFFF, 1'b0, 16'd4, 8'd5},
        '{24'h000020, 16'd6, 16'd60, 24'hFFFFFF, 1'b0, 16'd6, 8'hFF},
        '{24'h000030, 16'd8, 16'd10, 24'h000033, 1'b1, 16'd4, 8'hFF},
        '{24'h000008, 16'd3, 16'd15, 24'h00000A, 1'b0, 16'd3, 8'hFF},
        '{24'h00003C, 16'd0, 16'd10, 24'hFFFFFF, 1'b0, 16'd0, 8'd0}
    };
    localparam vec_t TW_VEC = '{24'h000004, 16'd5, 16'd30, 24'hFFFFFF, 1'b0, 16'd5, 8'd1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, use_tw = 1'b0, clear = 1'b1;
    logic [23:0] start_addr = '0;
    logic [15:0] byte_count = '0, busy_cfg = '0;
    logic [23:0] end_cfg = 24'hFFFFFF;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;

    logic rdy_p, done_p, err_p, sck_p, cs_p, mosi_p, miso_p;
    logic rdy_t, done_t, err_t, sck_t, cs_t, mosi_t, miso_t;
    int wren_p, wrdi_p, rdsr_p, prog_p, viol_p, gap_p;
    int wren_t, wrdi_t, rdsr_t, prog_t, viol_t, gap_t;
    logic [23:0] fa_p, fa_t;
    logic [63:0][7:0] mem_p, mem_t;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    aai_prog_seq #(.CLK_HALF(2), .CS_HIGH_CYC(CS_HI), .POLL_BUSY(1), .TBP_CYC(600), .CNT_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .start(start && !use_tw), .start_addr(start_addr),
        .byte_count(byte_count), .in_data(in_data), .in_valid(in_valid), .in_ready(rdy_p),
        .done(done_p), .error(err_p), .sck(sck_p), .cs_n(cs_p), .mosi(mosi_p), .miso(miso_p));

    aai_prog_seq #(.CLK_HALF(2), .CS_HIGH_CYC(CS_HI), .POLL_BUSY(0), .TBP_CYC(TBP), .CNT_W(16)) uut_tw (
        .clk(clk), .rst_n(rst_n), .start(start && use_tw), .start_addr(start_addr),
        .byte_count(byte_count), .in_data(in_data), .in_valid(in_valid), .in_ready(rdy_t),
        .done(done_t), .error(err_t), .sck(sck_t), .cs_n(cs_t), .mosi(mosi_t), .miso(miso_t));

    aai_flash_model fm_p (
        .clk(clk), .clear(clear), .cs_n(cs_p), .sck(sck_p), .mosi(mosi_p), .miso(miso_p),
        .busy_cyc(busy_cfg), .end_addr(end_cfg), .n_wren(wren_p), .n_wrdi(wrdi_p),
        .n_rdsr(rdsr_p), .n_prog(prog_p), .viol(viol_p), .min_gap(gap_p),
        .first_addr(fa_p), .mem(mem_p));

    aai_flash_model fm_t (
        .clk(clk), .clear(clear), .cs_n(cs_t), .sck(sck_t), .mosi(mosi_t), .miso(miso_t),
        .busy_cyc(16'd30), .end_addr(24'hFFFFFF), .n_wren(wren_t), .n_wrdi(wrdi_t),
        .n_rdsr(rdsr_t), .n_prog(prog_t), .viol(viol_t), .min_gap(gap_t),
        .first_addr(fa_t), .mem(mem_t));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int v, input int k);
        return 8'h3C ^ 8'(k * 29 + v * 7);
    endfunction

    task automatic run(input int v, input vec_t tv, input bit tw);
        int  k, n_wren, n_wrdi, n_rdsr, n_prog, n_viol, n_gap;
        bit  hs, got_done, got_err, finished;
        logic [23:0] fa;
        logic [63:0][7:0] mm;
        use_tw   = tw;
        busy_cfg = tv.busy;
        end_cfg  = tv.end_a;
        clear    = 1'b1;
        repeat (2) @(negedge clk);
        clear      = 1'b0;
        start_addr = tv.addr;
        byte_count = tv.cnt;
        k          = 0;
        in_data    = pat(v, 0);
        in_valid   = (tv.cnt != 0);
        start      = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        hs       = 1'b0;
        got_done = 1'b0;
        got_err  = 1'b0;
        finished = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            if (hs) begin
                k++;
                in_data = pat(v, k);
                if (k >= int'(tv.cnt)) in_valid = 1'b0;
            end
            got_done = tw ? done_t : done_p;
            got_err  = tw ? err_t  : err_p;
            if (got_done || got_err) begin
                finished = 1'b1;
                break;
            end
            hs = (tw ? rdy_t : rdy_p) && in_valid;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);

        n_wren = tw ? wren_t : wren_p;  n_wrdi = tw ? wrdi_t : wrdi_p;
        n_rdsr = tw ? rdsr_t : rdsr_p;  n_prog = tw ? prog_t : prog_p;
        n_viol = tw ? viol_t : viol_p;  n_gap  = tw ? gap_t  : gap_p;
        fa     = tw ? fa_t : fa_p;      mm     = tw ? mem_t : mem_p;

        check(finished, "R9/R10", $sformatf("vec %0d run ends", v), finished, 1);
        check(got_done == !tv.err, "R9", $sformatf("vec %0d done pulse", v), got_done, !tv.err);
        check(got_err == tv.err, "R10", $sformatf("vec %0d error pulse", v), got_err, tv.err);
        check(n_wren == ((tv.cnt != 0) ? 1 : 0), "R3", $sformatf("vec %0d write-enable frames", v),
              n_wren, (tv.cnt != 0) ? 1 : 0);
        check(n_viol == 0, "R4/R6", $sformatf("vec %0d frame or busy violations", v), n_viol, 0);
        check(n_prog == int'(tv.prog), "R4", $sformatf("vec %0d bytes programmed", v), n_prog, tv.prog);
        check(k == int'(tv.prog), "R8", $sformatf("vec %0d bytes accepted", v), k, tv.prog);
        check(n_wrdi == ((tv.cnt != 0 && !tv.err) ? 1 : 0), "R9/R10",
              $sformatf("vec %0d write-disable frames", v), n_wrdi, (tv.cnt != 0 && !tv.err) ? 1 : 0);
        if (tv.rdsr != 8'hFF)
            check(n_rdsr == int'(tv.rdsr), tw ? "R7" : "R6",
                  $sformatf("vec %0d status reads", v), n_rdsr, tv.rdsr);
        if (tv.cnt == 0)
            check(n_gap == 100000, "R11", "zero count bus stays idle", n_gap, 100000);
        else
            check(n_gap >= CS_HI, "R5", $sformatf("vec %0d min cs high", v), n_gap, CS_HI);
        if (tv.prog != 0)
            check(fa == tv.addr, "R4", $sformatf("vec %0d address bytes", v), fa, tv.addr);
        for (int j = 0; j < int'(tv.prog); j++)
            check(mm[6'(tv.addr + 24'(j))] == pat(v, j), "R2/R4",
                  $sformatf("vec %0d data byte %0d", v, j), mm[6'(tv.addr + 24'(j))], pat(v, j));
        check(mm[6'(tv.addr + 24'(tv.prog))] == 8'hFF, "R10",
              $sformatf("vec %0d byte past run untouched", v),
              mm[6'(tv.addr + 24'(tv.prog))], 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_p == 1'b1, "R1", "cs_n in reset", cs_p, 1);
        check(sck_p == 1'b0, "R1", "sck in reset", sck_p, 0);
        check(rdy_p == 1'b0, "R1", "in_ready in reset", rdy_p, 0);
        check(done_p == 1'b0 && err_p == 1'b0, "R1", "end pulses in reset", {done_p, err_p}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 6; v++) run(v, VECS[v], 1'b0);

        // fixed-wait variant: one status read only, the final one (R7)
        run(9, TW_VEC, 1'b1);

        // short start pulse for a zero count after a full run (R11, R12)
        run(7, VECS[5], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule